// File: doc/BRIEF.md
# Flash Program Command Decoder

This block sits between a host write bus and the program/erase controller of a two-bank flash array. Each host write cycle brings an address and a 16-bit data word. The block turns the stream of writes into program requests. It handles single-word program and double-word program, each in a normal unlocked form and in a shortened bypass form. For each request it captures the target address and data so that the controller can act on them.

While a program operation is running, or after a command has been aborted, the block raises a select for reads that fall in the affected bank. The read mux then returns a status word instead of array data. The status word has three meaningful bits:

- bit 7 reads 0 while work is in progress.
- bit 6 flips on every status read while work is in progress.
- bit 5 is the error flag.

Address and data are both captured on the clock edge that samples the final write strobe. The controller itself applies the rule that programming can only clear bits, so that the new cell value is the old value AND the written data.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset no request is pending. `busy`-driven status bit 7 reads 1, the error bit 5 reads 0, `inBypass` is 0 and `statusSel` is 0.
- R2: The sequence AAh@555h, 55h@2AAh, A0h@555h, then a write of (T, D) raises `progReq` for exactly one cycle after the fourth write, with `progAddr`=T, `progData`=D and `progDouble`=0. Commands are decoded from data bits 7:0 and address bits 10:0.
- R3: If an unlock write carries the wrong address or data, the decoder returns to read mode. A later A0h write on its own then starts no program.
- R4: Unlock followed by 20h@555h enters bypass (`inBypass`=1). In bypass, A0h at any address followed by (T, D) issues a single-word request. 90h followed by 00h, both at any address, leaves bypass.
- R5: In bypass, a command byte other than A0h, 40h or 90h is ignored: no request is issued and bypass stays active. A 90h followed by any byte other than 00h stays in bypass.
- R6: Double-word program is command 40h, given either after the unlock cycles at 555h or in bypass at any address. It is followed by (T1, D1) and (T2, D2), and issues one request with `progDouble`=1, `progAddr`/`progData`=T1/D1 and `progAddr2`/`progData2`=T2/D2.
- R7: In a double-word program, any of the following aborts the command with no request and sets status bit 5:
  - T2 differs from T1 in any address bit other than bit 0;
  - `vppOk` is low when the 40h command is written;
  - `vppOk` is low when the second word is written.
- R8: From a request until `pecDone`, three things hold:
  - reads whose address bit 11 equals the bank of the target get `statusSel`=1, and reads in the other bank get 0;
  - status bit 7 is 0 and bit 6 toggles on each selected read;
  - host writes are ignored.
- R9: The error bit is cleared by an F0h write in read mode or by the next issued request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write cycle strobe |
| wrAddr | input | ADDR_W | Write cycle address |
| wrData | input | DATA_W | Write cycle data |
| vppOk | input | 1 | High-voltage supply present |
| rdEn | input | 1 | Host read strobe |
| rdAddr | input | ADDR_W | Read address |
| pecDone | input | 1 | Controller finished the operation |
| progReq | output | 1 | One-cycle program request |
| progDouble | output | 1 | Request is a double-word program |
| progAddr | output | ADDR_W | First target address |
| progData | output | DATA_W | First data word |
| progAddr2 | output | ADDR_W | Second target address |
| progData2 | output | DATA_W | Second data word |
| inBypass | output | 1 | Bypass mode active |
| statusSel | output | 1 | Current read returns the status word |
| statusWord | output | DATA_W | Status word |

## Verification
The assertions assume the following about the inputs:
- `pecDone` arrives only while an operation is busy;
- `wrEn` is a clean one-cycle strobe whose address and data are stable on the sampling edge;
- `ADDR_W` is at least 12, so that the unlock addresses and the bank bit fit.

The bench keeps within these bounds. It drives every input on the falling clock edge and holds each write for one rising edge. It pulses `pecDone` only after it has seen a request. It keeps the default 12-bit address width.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef struct packed {
    logic ldFirst;
    logic ldSecond;
    logic fire;
    logic dbl;
    logic setErr;
    logic clrErr;
  } fcdStrobe_t;
endpackage

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        cmd,
  input  logic              vppOk,
  input  logic              busy,
  input  logic              pairOk,
  output fcdStrobe_t        stb,
  output logic              inBypass
);
  typedef enum logic [2:0] {
    S_READ, S_UNL1, S_UNL2, S_BYP, S_BEX, S_PGA, S_DWA, S_DWB
  } state_t;

  localparam logic [10:0] ADDR_A = 11'h555;
  localparam logic [10:0] ADDR_B = 11'h2AA;

  state_t state, nxt;
  logic   byp, nxtByp;
  logic   atA, atB;
  state_t home;

  assign atA  = (wrAddr[10:0] == ADDR_A);
  assign atB  = (wrAddr[10:0] == ADDR_B);
  assign home = byp ? S_BYP : S_READ;

  always_comb begin
    nxt    = state;
    nxtByp = byp;
    stb    = '0;
    if (wrEn && !busy) begin
      case (state)
        S_READ: begin
          if (atA && cmd == 8'hAA) nxt = S_UNL1;
          else if (cmd == 8'hF0)   stb.clrErr = 1'b1;
        end
        S_UNL1: nxt = (atB && cmd == 8'h55) ? S_UNL2 : S_READ;
        S_UNL2: begin
          nxt = S_READ;
          if (atA) begin
            case (cmd)
              8'hA0: nxt = S_PGA;
              8'h40: if (vppOk) nxt = S_DWA; else stb.setErr = 1'b1;
              8'h20: begin nxt = S_BYP; nxtByp = 1'b1; end
              default: nxt = S_READ;
            endcase
          end
        end
        S_BYP: begin
          case (cmd)
            8'hA0: nxt = S_PGA;
            8'h40: if (vppOk) nxt = S_DWA; else stb.setErr = 1'b1;
            8'h90: nxt = S_BEX;
            default: nxt = S_BYP;
          endcase
        end
        S_BEX: begin
          if (cmd == 8'h00) begin nxt = S_READ; nxtByp = 1'b0; end
          else nxt = S_BYP;
        end
        S_PGA: begin
          stb.ldFirst = 1'b1;
          stb.fire    = 1'b1;
          stb.clrErr  = 1'b1;
          nxt         = home;
        end
        S_DWA: begin
          stb.ldFirst = 1'b1;
          nxt         = S_DWB;
        end
        S_DWB: begin
          if (pairOk && vppOk) begin
            stb.ldSecond = 1'b1;
            stb.fire     = 1'b1;
            stb.dbl      = 1'b1;
            stb.clrErr   = 1'b1;
          end else begin
            stb.setErr = 1'b1;
          end
          nxt = home;
        end
        default: nxt = S_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_READ;
      byp   <= 1'b0;
    end else begin
      state <= nxt;
      byp   <= nxtByp;
    end
  end

  assign inBypass = byp;

  // R8: a write during a busy operation leaves the sequencer where it was
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn) |=> (state == $past(state)));
  // R5: bypass is only left through the exit state
  a_r5_bypass_kept: assert property (@(posedge clk) disable iff (!rstN)
    (byp && state != S_BEX) |=> byp);
  // R4: entering bypass happens only from the third unlocked cycle
  a_r4_bypass_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(byp) |-> ($past(state) == S_UNL2));
endmodule

// File: rtl/fcd_dpath.sv
module fcd_dpath
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fcdStrobe_t        stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              pecDone,
  output logic              pairOk,
  output logic              busy,
  output logic              progReq,
  output logic              progDouble,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progData,
  output logic [ADDR_W-1:0] progAddr2,
  output logic [DATA_W-1:0] progData2,
  output logic              statusSel,
  output logic [DATA_W-1:0] statusWord
);
  localparam int BANK_BIT = 11;

  logic err, toggle, bank;

  assign pairOk    = (wrAddr[ADDR_W-1:1] == progAddr[ADDR_W-1:1]);
  assign statusSel = (busy || err) && (rdAddr[BANK_BIT] == bank);

  always_comb begin
    statusWord    = '0;
    statusWord[7] = ~busy;
    statusWord[6] = toggle;
    statusWord[5] = err;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progAddr   <= '0;
      progData   <= '0;
      progAddr2  <= '0;
      progData2  <= '0;
      progReq    <= 1'b0;
      progDouble <= 1'b0;
      busy       <= 1'b0;
      err        <= 1'b0;
      toggle     <= 1'b0;
      bank       <= 1'b0;
    end else begin
      progReq <= stb.fire;
      if (stb.ldFirst) begin
        progAddr <= wrAddr;
        progData <= wrData;
      end
      if (stb.ldSecond) begin
        progAddr2 <= wrAddr;
        progData2 <= wrData;
      end
      if (stb.fire) begin
        progDouble <= stb.dbl;
        busy       <= 1'b1;
        toggle     <= 1'b0;
      end else if (pecDone) begin
        busy <= 1'b0;
      end else if (rdEn && statusSel && busy) begin
        toggle <= ~toggle;
      end
      if (stb.fire || stb.setErr) bank <= wrAddr[BANK_BIT];
      if (stb.setErr)      err <= 1'b1;
      else if (stb.clrErr) err <= 1'b0;
    end
  end

  // R2: a request lasts a single cycle
  a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    progReq |=> !progReq);
  // R8: a request always comes with the busy state
  a_r8_busy_on_req: assert property (@(posedge clk) disable iff (!rstN)
    progReq |-> busy);
  // R6: a double request always carries an adjacent pair
  a_r6_pair: assert property (@(posedge clk) disable iff (!rstN)
    (progReq && progDouble) |-> (progAddr2[ADDR_W-1:1] == progAddr[ADDR_W-1:1]));
  // R7: an abort never coincides with a request
  a_r7_abort_no_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> !progReq);
  // R8: status is selected only while busy or in error
  a_r8_status_sel: assert property (@(posedge clk) disable iff (!rstN)
    statusSel |-> (busy || err));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              vppOk,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              pecDone,
  output logic              progReq,
  output logic              progDouble,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progData,
  output logic [ADDR_W-1:0] progAddr2,
  output logic [DATA_W-1:0] progData2,
  output logic              inBypass,
  output logic              statusSel,
  output logic [DATA_W-1:0] statusWord
);
  fcdStrobe_t stb;
  logic busy, pairOk;

  fcd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .cmd(wrData[7:0]),
    .vppOk(vppOk), .busy(busy), .pairOk(pairOk), .stb(stb), .inBypass(inBypass)
  );

  fcd_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .pecDone(pecDone), .pairOk(pairOk),
    .busy(busy), .progReq(progReq), .progDouble(progDouble),
    .progAddr(progAddr), .progData(progData), .progAddr2(progAddr2),
    .progData2(progData2), .statusSel(statusSel), .statusWord(statusWord)
  );
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        vppOk = 1'b1;
  logic        rdEn = 1'b0;
  logic [11:0] rdAddr = '0;
  logic        pecDone = 1'b0;
  logic        progReq, progDouble, inBypass, statusSel;
  logic [11:0] progAddr, progAddr2;
  logic [15:0] progData, progData2, statusWord;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .vppOk(vppOk), .rdEn(rdEn), .rdAddr(rdAddr), .pecDone(pecDone),
    .progReq(progReq), .progDouble(progDouble), .progAddr(progAddr),
    .progData(progData), .progAddr2(progAddr2), .progData2(progData2),
    .inBypass(inBypass), .statusSel(statusSel), .statusWord(statusWord)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic unlock();
    wr(12'h555, 16'h00AA);
    wr(12'h2AA, 16'h0055);
  endtask

  task automatic rdPulse(input logic [11:0] a);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic done();
    @(negedge clk);
    pecDone = 1'b1;
    @(negedge clk);
    pecDone = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1..R9 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 progReq", progReq, 0);
    chk("R1 inBypass", inBypass, 0);
    chk("R1 status bit7", statusWord[7], 1);
    chk("R1 status bit5", statusWord[5], 0);
    chk("R1 statusSel", statusSel, 0);

    // R2 normal single-word program
    unlock();
    wr(12'h555, 16'hBEA0);
    chk("R2 no req after cmd", progReq, 0);
    wr(12'h9F3, 16'h1234);
    chk("R2 req", progReq, 1);
    chk("R2 addr", progAddr, 12'h9F3);
    chk("R2 data", progData, 16'h1234);
    chk("R2 single", progDouble, 0);
    @(negedge clk);
    chk("R2 one cycle", progReq, 0);

    // R8 status while busy
    rdAddr = 12'h800; #1;
    chk("R8 sel same bank", statusSel, 1);
    chk("R8 bit7 busy", statusWord[7], 0);
    chk("R8 bit6 start", statusWord[6], 0);
    rdAddr = 12'h100; #1;
    chk("R8 sel other bank", statusSel, 0);
    rdPulse(12'h8AB);
    chk("R8 toggle 1", statusWord[6], 1);
    rdPulse(12'h8AB);
    chk("R8 toggle 2", statusWord[6], 0);
    unlock();
    wr(12'h555, 16'h00A0);
    wr(12'h123, 16'h4444);
    chk("R8 writes ignored", progReq, 0);
    done();
    rdAddr = 12'h800; #1;
    chk("R8 done sel", statusSel, 0);
    chk("R8 done bit7", statusWord[7], 1);
    wr(12'h123, 16'h4444);
    chk("R8 no leftover seq", progReq, 0);

    // R3 broken unlock
    wr(12'h555, 16'h00AA);
    wr(12'h2AA, 16'h0056);
    wr(12'h555, 16'h00A0);
    wr(12'h321, 16'h7777);
    chk("R3 bad data", progReq, 0);
    wr(12'h554, 16'h00AA);
    wr(12'h2AA, 16'h0055);
    wr(12'h555, 16'h00A0);
    wr(12'h321, 16'h7777);
    chk("R3 bad addr", progReq, 0);

    // R7 / R9 vpp missing at command
    vppOk = 1'b0;
    unlock();
    wr(12'h555, 16'h0040);
    wr(12'h010, 16'h1111);
    wr(12'h011, 16'h2222);
    chk("R7 vpp no req", progReq, 0);
    rdAddr = 12'h000; #1;
    chk("R7 vpp err bit5", statusWord[5], 1);
    chk("R7 vpp sel", statusSel, 1);
    vppOk = 1'b1;
    wr(12'h000, 16'h00F0);
    chk("R9 F0 clears", statusWord[5], 0);

    // R6 normal double-word
    unlock();
    wr(12'h555, 16'h0040);
    wr(12'h8A4, 16'hAAAA);
    chk("R6 no req after first", progReq, 0);
    wr(12'h8A5, 16'h5555);
    chk("R6 req", progReq, 1);
    chk("R6 dbl", progDouble, 1);
    chk("R6 a1", progAddr, 12'h8A4);
    chk("R6 d1", progData, 16'hAAAA);
    chk("R6 a2", progAddr2, 12'h8A5);
    chk("R6 d2", progData2, 16'h5555);
    done();

    // R4 enter bypass
    unlock();
    wr(12'h555, 16'h0020);
    chk("R4 entered", inBypass, 1);

    // R4/R5/R6 sweep over all command bytes in bypass
    for (int c = 0; c < 256; c++) begin
      wr(12'h3C7, {8'h5A, c[7:0]});
      if (c == 8'hA0) begin
        wr(12'h8C4, 16'h1F34);
        chk("R4 byp single req", progReq, 1);
        chk("R4 byp single addr", progAddr, 12'h8C4);
        chk("R4 byp single dbl", progDouble, 0);
        rdAddr = 12'h8C4; #1;
        chk("R8 byp sel", statusSel, 1);
        done();
      end else if (c == 8'h40) begin
        wr(12'h8C4, 16'h1F34);
        wr(12'h8C5, 16'h0E34);
        chk("R6 byp dbl req", progReq, 1);
        chk("R6 byp dbl flag", progDouble, 1);
        chk("R6 byp d2", progData2, 16'h0E34);
        done();
      end else begin
        wr(12'h8C4, 16'h1F34);
        chk("R5 ignored no req", progReq, 0);
      end
      chk("R5 still bypass", inBypass, 1);
    end

    // R7 pair mismatch on every upper address bit
    for (int b = 1; b < 12; b++) begin
      wr(12'h000, 16'h0040);
      wr(12'h400, 16'h1111);
      wr(12'h400 ^ (12'h1 << b), 16'h2222);
      chk("R7 mismatch no req", progReq, 0);
      chk("R7 mismatch err", statusWord[5], 1);
    end

    // R7 vpp dropped at second word
    wr(12'h000, 16'h0040);
    wr(12'h402, 16'h1111);
    vppOk = 1'b0;
    wr(12'h403, 16'h2222);
    vppOk = 1'b1;
    chk("R7 vpp second no req", progReq, 0);

    // R9 next request clears error
    wr(12'h000, 16'h00A0);
    wr(12'h456, 16'h0F0F);
    chk("R9 req clears err", statusWord[5], 0);
    done();

    // R4 exit bypass
    wr(12'h777, 16'h0090);
    wr(12'h123, 16'h0000);
    chk("R4 exited", inBypass, 0);
    wr(12'h000, 16'h00A0);
    wr(12'h456, 16'h0F0F);
    chk("R4 no bypass program after exit", progReq, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule